// File: doc/BRIEF.md
# CAN Controller Interrupt Request Logic

This block forms the single interrupt request of an on-chip CAN controller. It holds the controller's 8-bit status register, which the protocol engine loads through an update strobe and the processor reads and writes through simple strobes. Two independent sources feed the interrupt line. The status-change source raises a pending flag whenever an engine update alters a status bit whose group is enabled. The event source raises a request flag when a successful receive or transmit is reported for an enabled direction, and it records the highest message-object number seen in a vector register.

The two sources have separate clearing paths. Reading the status register acknowledges a status-change interrupt. It also loads the error-code field with all ones, so software can detect a fresh error code on the next read. Software clears event interrupts by writing zero to the request flag, and the vector is cleared with it. Several status changes that arrive before an acknowledge merge into one pending interrupt. Engine updates and new events always take priority over a clear in the same cycle.

Status layout: bits 2:0 hold the error code, bit 3 is receive-ok, bit 4 is transmit-ok, bit 5 is wake-up, bit 6 is error-warning and bit 7 is bus-off. Bits 5:0 form the low group and bits 7:6 form the high group.

Top module: `can_stat_irq`

## Requirements
- R1: After a synchronous reset, `status_o` is 8'h00, and `irq_o`, `intrq_o` and `vec_o` are all 0.
- R2: An engine update (`st_upd_i`) that changes any of status bits 5:0 sets the status-change pending flag and drives `irq_o` high from the next cycle, but only when `stie_en_i` is 1. When `stie_en_i` is 0, or when the update value equals the current status, no interrupt is raised.
- R3: An engine update that changes status bit 7 or bit 6 raises the status-change interrupt only when `erie_en_i` is 1.
- R4: A processor read (`st_rd_i`) with no engine update in the same cycle clears the pending status-change flag. A later change of bits that software never cleared raises a new interrupt.
- R5: Several qualifying status changes before a read leave exactly one pending flag, and a single read clears it.
- R6: A processor read with no engine update or write in the same cycle sets status bits 2:0 to 3'b111 and leaves bits 7:3 unchanged.
- R7: A processor write (`st_wr_i`) with no engine update loads every status bit except bit 5, which keeps its value. Processor writes and the read-forced error code never raise an interrupt.
- R8: With `stie_en_i` = 0 and `eri_en_i` = 1, a `rx_ok_i` pulse sets `intrq_o` and `irq_o` from the next cycle. When `eri_en_i` = 0, when `stie_en_i` = 1, or when there is no pulse, neither flag is set.
- R9: With `stie_en_i` = 0 and `eti_en_i` = 1, a `tx_ok_i` pulse behaves the same way as a qualifying receive.
- R10: On a qualifying event, `vec_o` takes the event's object number only if that number is greater than the value it holds. When a receive and a transmit qualify together, the larger of the two numbers is the candidate.
- R11: An `intrq_clr_i` pulse clears `intrq_o` and resets `vec_o` to 0. If a qualifying event arrives in the same cycle, `intrq_o` stays 1 and `vec_o` becomes that event's object number.
- R12: Status-change interrupts and status reads leave `intrq_o` unchanged. `irq_o` is the OR of the pending status-change flag and `intrq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| stie_en_i | input | 1 | Enable for status-change interrupts on bits 5:0; also selects polled mode |
| erie_en_i | input | 1 | Enable for status-change interrupts on bits 7:6 |
| eri_en_i | input | 1 | Receive event interrupt enable (hardwired mode) |
| eti_en_i | input | 1 | Transmit event interrupt enable (hardwired mode) |
| st_upd_i | input | 1 | Engine status update strobe |
| st_upd_data_i | input | 8 | Engine status value |
| st_wr_i | input | 1 | Processor status write strobe |
| st_wdata_i | input | 8 | Processor status write data |
| st_rd_i | input | 1 | Processor status read strobe (data is `status_o` in the same cycle) |
| status_o | output | 8 | Current status register |
| rx_ok_i | input | 1 | Successful reception pulse |
| rx_obj_i | input | 4 | Message object of the reception |
| tx_ok_i | input | 1 | Successful transmission pulse |
| tx_obj_i | input | 4 | Message object of the transmission |
| intrq_clr_i | input | 1 | Processor writes 0 to the request flag |
| irq_o | output | 1 | Interrupt line to the processor |
| intrq_o | output | 1 | Event request flag |
| vec_o | output | 4 | Highest pending message-object number |

## Verification
Every result is produced by one register stage. A strobe applied in cycle k is therefore visible on `status_o`, `irq_o`, `intrq_o` and `vec_o` after the clock edge that ends cycle k, with no extra latency for any source. The bench drives each stimulus at a falling edge, lets exactly one rising edge pass, and compares at the following falling edge. It keeps its own model of the status register, of the vector maximum and of both flags. It sweeps every status bit under every enable combination, every event direction under every enable combination, and a permuted series of object numbers for the vector.

// File: rtl/can_stat_irq_pkg.sv
package can_stat_irq_pkg;
  localparam int ST_W     = 8;
  localparam int ERR_W    = 3;
  localparam int WAKE_BIT = 5;

  localparam logic [ST_W-1:0] LOW_GRP  = 8'h3F;
  localparam logic [ST_W-1:0] HIGH_GRP = 8'hC0;
  localparam logic [ST_W-1:0] WAKE_MSK = ST_W'(1) << WAKE_BIT;
  localparam logic [ST_W-1:0] ERR_MSK  = ST_W'((1 << ERR_W) - 1);

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ENG  = 2'd1,
    SRC_WR   = 2'd2,
    SRC_RD   = 2'd3
  } st_src_e;
endpackage

// File: rtl/can_stat_reg.sv
module can_stat_reg
  import can_stat_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            stie_i,
  input  logic            erie_i,
  input  logic            upd_i,
  input  logic [ST_W-1:0] upd_d_i,
  input  logic            wr_i,
  input  logic [ST_W-1:0] wr_d_i,
  input  logic            rd_i,
  output logic [ST_W-1:0] stat_o,
  output logic            pend_o
);
  logic [ST_W-1:0] stat_q, stat_n, diff;
  logic            pend_q, pend_n, hit;
  st_src_e         src;

  always_comb begin
    if (upd_i)     src = SRC_ENG;
    else if (wr_i) src = SRC_WR;
    else if (rd_i) src = SRC_RD;
    else           src = SRC_NONE;
  end

  always_comb begin
    stat_n = stat_q;
    unique case (src)
      SRC_ENG:  stat_n = upd_d_i;
      SRC_WR:   stat_n = (wr_d_i & ~WAKE_MSK) | (stat_q & WAKE_MSK);
      SRC_RD:   stat_n = stat_q | ERR_MSK;
      default:  stat_n = stat_q;
    endcase
  end

  // only engine updates count as changes
  assign diff = (src == SRC_ENG) ? (upd_d_i ^ stat_q) : '0;
  assign hit  = (stie_i && |(diff & LOW_GRP)) || (erie_i && |(diff & HIGH_GRP));
  // set wins over the read acknowledge
  assign pend_n = hit || (pend_q && !rd_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stat_q <= '0;
      pend_q <= 1'b0;
    end else begin
      stat_q <= stat_n;
      pend_q <= pend_n;
    end
  end

  assign stat_o = stat_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/can_evt_intr.sv
module can_evt_intr #(
  parameter int N_SRC = 2,
  parameter int OBJ_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_i,
  input  logic                         hw_mode_i,
  input  logic [N_SRC-1:0]             en_i,
  input  logic [N_SRC-1:0]             ok_i,
  input  logic [N_SRC-1:0][OBJ_W-1:0]  obj_i,
  input  logic                         clr_i,
  output logic                         intrq_o,
  output logic [OBJ_W-1:0]             vec_o
);
  logic [N_SRC-1:0] qual;
  logic [OBJ_W-1:0] cand, base, vec_q, vec_n;
  logic             any, intrq_q, intrq_n;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_qual
      assign qual[g] = hw_mode_i && en_i[g] && ok_i[g];
    end
  endgenerate

  always_comb begin
    cand = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (qual[i] && obj_i[i] > cand) cand = obj_i[i];
    end
  end

  assign any     = |qual;
  assign base    = clr_i ? '0 : vec_q;
  assign vec_n   = (any && cand > base) ? cand : base;
  assign intrq_n = any || (intrq_q && !clr_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      intrq_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      intrq_q <= intrq_n;
      vec_q   <= vec_n;
    end
  end

  assign intrq_o = intrq_q;
  assign vec_o   = vec_q;
endmodule

// File: rtl/can_stat_irq.sv
module can_stat_irq
  import can_stat_irq_pkg::*;
#(
  parameter int OBJ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             stie_en_i,
  input  logic             erie_en_i,
  input  logic             eri_en_i,
  input  logic             eti_en_i,
  input  logic             st_upd_i,
  input  logic [ST_W-1:0]  st_upd_data_i,
  input  logic             st_wr_i,
  input  logic [ST_W-1:0]  st_wdata_i,
  input  logic             st_rd_i,
  output logic [ST_W-1:0]  status_o,
  input  logic             rx_ok_i,
  input  logic [OBJ_W-1:0] rx_obj_i,
  input  logic             tx_ok_i,
  input  logic [OBJ_W-1:0] tx_obj_i,
  input  logic             intrq_clr_i,
  output logic             irq_o,
  output logic             intrq_o,
  output logic [OBJ_W-1:0] vec_o
);
  localparam int N_SRC = 2;

  logic                        sc_pend;
  logic [N_SRC-1:0]            ev_en, ev_ok;
  logic [N_SRC-1:0][OBJ_W-1:0] ev_obj;

  can_stat_reg u_stat (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .stie_i  (stie_en_i),
    .erie_i  (erie_en_i),
    .upd_i   (st_upd_i),
    .upd_d_i (st_upd_data_i),
    .wr_i    (st_wr_i),
    .wr_d_i  (st_wdata_i),
    .rd_i    (st_rd_i),
    .stat_o  (status_o),
    .pend_o  (sc_pend)
  );

  assign ev_en  = {eti_en_i, eri_en_i};
  assign ev_ok  = {tx_ok_i, rx_ok_i};
  assign ev_obj = {tx_obj_i, rx_obj_i};

  can_evt_intr #(.N_SRC(N_SRC), .OBJ_W(OBJ_W)) u_evt (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .hw_mode_i (!stie_en_i),
    .en_i      (ev_en),
    .ok_i      (ev_ok),
    .obj_i     (ev_obj),
    .clr_i     (intrq_clr_i),
    .intrq_o   (intrq_o),
    .vec_o     (vec_o)
  );

  assign irq_o = sc_pend | intrq_o;
endmodule

// File: rtl/can_stat_irq_chk.sv
module can_stat_irq_chk #(
  parameter int OBJ_W = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             stie_en_i,
  input logic             erie_en_i,
  input logic             eri_en_i,
  input logic             eti_en_i,
  input logic             st_upd_i,
  input logic [7:0]       st_upd_data_i,
  input logic             st_wr_i,
  input logic             st_rd_i,
  input logic [7:0]       status_o,
  input logic             rx_ok_i,
  input logic             tx_ok_i,
  input logic             intrq_clr_i,
  input logic             irq_o,
  input logic             intrq_o,
  input logic [OBJ_W-1:0] vec_o,
  input logic             sc_pend
);
  logic rx_q, tx_q;
  assign rx_q = rx_ok_i && eri_en_i && !stie_en_i;
  assign tx_q = tx_ok_i && eti_en_i && !stie_en_i;

  // R2
  low_change_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_upd_i && stie_en_i && (((st_upd_data_i ^ status_o) & 8'h3F) != 8'h00)) |=> irq_o);
  // R3
  high_change_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_upd_i && erie_en_i && (((st_upd_data_i ^ status_o) & 8'hC0) != 8'h00)) |=> irq_o);
  // R4
  rd_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_rd_i && !st_upd_i) |=> !sc_pend);
  // R6
  rd_force_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_rd_i && !st_upd_i && !st_wr_i) |=> (status_o[2:0] == 3'b111));
  // R7
  wake_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_wr_i && !st_upd_i) |=> (status_o[5] == $past(status_o[5])));
  // R8
  rx_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rx_q |=> (intrq_o && irq_o));
  // R9
  tx_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_q |=> (intrq_o && irq_o));
  // R10
  vec_mono_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !intrq_clr_i |=> (vec_o >= $past(vec_o)));
  // R11
  clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (intrq_clr_i && !rx_q && !tx_q) |=> (!intrq_o && vec_o == '0));
  // R12
  intrq_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!intrq_clr_i && !rx_q && !tx_q) |=> $stable(intrq_o));
endmodule

bind can_stat_irq can_stat_irq_chk #(.OBJ_W(OBJ_W)) u_chk (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .stie_en_i     (stie_en_i),
  .erie_en_i     (erie_en_i),
  .eri_en_i      (eri_en_i),
  .eti_en_i      (eti_en_i),
  .st_upd_i      (st_upd_i),
  .st_upd_data_i (st_upd_data_i),
  .st_wr_i       (st_wr_i),
  .st_rd_i       (st_rd_i),
  .status_o      (status_o),
  .rx_ok_i       (rx_ok_i),
  .tx_ok_i       (tx_ok_i),
  .intrq_clr_i   (intrq_clr_i),
  .irq_o         (irq_o),
  .intrq_o       (intrq_o),
  .vec_o         (vec_o),
  .sc_pend       (sc_pend)
);

// File: tb/can_stat_irq_bench.sv
`timescale 1ns/1ps
module can_stat_irq_bench;
  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic       stie_en_i = 0, erie_en_i = 0, eri_en_i = 0, eti_en_i = 0;
  logic       st_upd_i = 0, st_wr_i = 0, st_rd_i = 0;
  logic [7:0] st_upd_data_i = '0, st_wdata_i = '0;
  logic [7:0] status_o;
  logic       rx_ok_i = 0, tx_ok_i = 0, intrq_clr_i = 0;
  logic [3:0] rx_obj_i = '0, tx_obj_i = '0;
  logic       irq_o, intrq_o;
  logic [3:0] vec_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] st_m;
  logic [3:0] vm;

  always #2.5 clk = ~clk;

  can_stat_irq u_can_stat_irq (
    .clk_i(clk), .rst_i(rst_i),
    .stie_en_i(stie_en_i), .erie_en_i(erie_en_i),
    .eri_en_i(eri_en_i), .eti_en_i(eti_en_i),
    .st_upd_i(st_upd_i), .st_upd_data_i(st_upd_data_i),
    .st_wr_i(st_wr_i), .st_wdata_i(st_wdata_i),
    .st_rd_i(st_rd_i), .status_o(status_o),
    .rx_ok_i(rx_ok_i), .rx_obj_i(rx_obj_i),
    .tx_ok_i(tx_ok_i), .tx_obj_i(tx_obj_i),
    .intrq_clr_i(intrq_clr_i), .irq_o(irq_o),
    .intrq_o(intrq_o), .vec_o(vec_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic eng(input logic [7:0] v);
    st_upd_i = 1; st_upd_data_i = v; tick; st_upd_i = 0; st_m = v;
  endtask

  task automatic rd;
    st_rd_i = 1; tick; st_rd_i = 0; st_m[2:0] = 3'b111;
  endtask

  task automatic clr;
    intrq_clr_i = 1; tick; intrq_clr_i = 0; vm = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    st_m = '0; vm = '0;
    @(negedge clk); tick; tick;
    rst_i = 0;
    // R1 reset state
    chk("R1 status", status_o, 8'h00);
    chk("R1 irq", irq_o, 0);
    chk("R1 intrq", intrq_o, 0);
    chk("R1 vec", vec_o, 0);

    // R2/R3/R4/R6 sweep: every bit under every enable pair
    for (int m = 0; m < 4; m++) begin
      stie_en_i = m[0]; erie_en_i = m[1];
      for (int b = 0; b < 8; b++) begin
        eng(st_m ^ (8'h01 << b));
        chk("R2/R3 status load", status_o, st_m);
        if (b < 6) chk("R2 low bit irq", irq_o, stie_en_i);
        else       chk("R3 high bit irq", irq_o, erie_en_i);
        chk("R12 intrq untouched", intrq_o, 0);
        rd;
        chk("R4 read clears", irq_o, 0);
        chk("R6 err field forced", status_o, st_m);
      end
    end

    // R2 equal value raises nothing
    stie_en_i = 1; erie_en_i = 1;
    eng(st_m);
    chk("R2 no change", irq_o, 0);

    // R5 merge, R4 re-raise without clearing bits
    erie_en_i = 0;
    eng(st_m ^ 8'h08);
    eng(st_m ^ 8'h10);
    chk("R5 merged pending", irq_o, 1);
    rd;
    chk("R5 single read clears", irq_o, 0);
    eng(st_m ^ 8'h08);
    chk("R4 new change re-raises", irq_o, 1);
    rd;
    chk("R4 cleared again", irq_o, 0);

    // R7 processor write keeps wake bit, raises nothing
    erie_en_i = 1;
    eng(8'h20); rd;
    st_wr_i = 1; st_wdata_i = 8'h00; tick; st_wr_i = 0;
    chk("R7 wake kept set", status_o, 8'h20);
    chk("R7 no irq on write", irq_o, 0);
    st_wr_i = 1; st_wdata_i = 8'hDF; tick; st_wr_i = 0;
    chk("R7 write loads", status_o, 8'hFF);
    eng(8'h00);
    rd;
    st_wr_i = 1; st_wdata_i = 8'hFF; tick; st_wr_i = 0;
    chk("R7 wake kept clear", status_o, 8'hDF);
    chk("R7 no irq", irq_o, 0);
    st_m = 8'hDF;
    rd;
    chk("R7 forced code no irq", irq_o, 0);

    // R8/R9 enable sweep
    erie_en_i = 0;
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 2; s++) begin
        logic q;
        stie_en_i = m[0]; eri_en_i = m[1]; eti_en_i = m[2];
        clr;
        chk("R11 clear", intrq_o, 0);
        q = !stie_en_i && (s == 0 ? eri_en_i : eti_en_i);
        if (s == 0) begin rx_ok_i = 1; rx_obj_i = 4'd5; end
        else        begin tx_ok_i = 1; tx_obj_i = 4'd5; end
        tick; rx_ok_i = 0; tx_ok_i = 0;
        if (s == 0) chk("R8 rx intrq", intrq_o, q);
        else        chk("R9 tx intrq", intrq_o, q);
        chk("R12 irq or", irq_o, q);
        chk("R10 vec on event", vec_o, q ? 4'd5 : 4'd0);
      end
    end

    // R10 vector sweep
    stie_en_i = 0; eri_en_i = 1; eti_en_i = 1;
    clr;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] o;
      o = 4'((i * 7) % 16);
      rx_ok_i = 1; rx_obj_i = o; tick; rx_ok_i = 0;
      if (o > vm) vm = o;
      chk("R10 vec max", vec_o, vm);
    end
    clr;
    rx_ok_i = 1; rx_obj_i = 4'd3; tx_ok_i = 1; tx_obj_i = 4'd9; tick;
    rx_ok_i = 0; tx_ok_i = 0;
    chk("R10 both same cycle", vec_o, 4'd9);
    rx_ok_i = 1; rx_obj_i = 4'd12; tx_ok_i = 1; tx_obj_i = 4'd2; tick;
    rx_ok_i = 0; tx_ok_i = 0;
    chk("R10 rx larger", vec_o, 4'd12);

    // R11 clear alone, then clear with event
    clr;
    chk("R11 intrq cleared", intrq_o, 0);
    chk("R11 vec cleared", vec_o, 0);
    rx_ok_i = 1; rx_obj_i = 4'd11; tick; rx_ok_i = 0;
    intrq_clr_i = 1; tx_ok_i = 1; tx_obj_i = 4'd4; tick;
    intrq_clr_i = 0; tx_ok_i = 0;
    chk("R11 event wins intrq", intrq_o, 1);
    chk("R11 event wins vec", vec_o, 4'd4);

    // R12 status read leaves intrq; sc pending survives intrq clear
    rd;
    chk("R12 read keeps intrq", intrq_o, 1);
    erie_en_i = 1;
    eng(st_m ^ 8'h80);
    chk("R12 intrq unchanged by status", intrq_o, 1);
    clr;
    chk("R12 intrq cleared", intrq_o, 0);
    chk("R12 irq from status pending", irq_o, 1);
    rd;
    chk("R12 irq low", irq_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule